// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block produces data addresses for a DSP datapath. It keeps a bank of pointer registers (index), step registers (modify) and buffer-size registers (length). An access presents the chosen pointer as the memory address in the same cycle. On the next clock edge the pointer moves by the chosen step. When the pointer's length register is non-zero, the move wraps inside a circular buffer of that length. When it is zero, the move is plain linear arithmetic on 14 bits.

The bank is split into two halves that work as two generators. The lower half can only address data memory. The upper half can also target program memory, and a port-select output reports which space is in use. Software loads and inspects all registers through a simple write port and a combinational read port. Address requests are single-cycle strobes with no back-pressure: the address is valid in the cycle the strobe is high, and a strobe is always accepted.

Top module: `circ_agu`

## Requirements
- R1: After reset, every index, modify and length register reads back as zero.
- R2: A write with kind 0 (index), 1 (modify) or 2 (length) to register number 0..7 is readable on the read port from the next cycle on. A write with kind 3 changes no register, and a read with kind 3 returns zero.
- R3: While `acc_en` is high, `addr_o` equals the current value of index register `acc_num` and `addr_vld_o` is high. While `acc_en` is low, both are zero.
- R4: With length register n equal to zero, an access on index n sets it to (index + modify) mod 16384 on the next edge. The modify value is read as a 14-bit two's-complement number.
- R5: With length L non-zero, let P be the smallest power of two not below L and base = index with its low log2(P) bits cleared. If modify is non-negative and index + modify is at least base + L, the new index is index + modify - L.
- R6: Under the same conditions, if modify is negative and index + modify is below base, the new index is index + modify + L. Otherwise the new index is index + modify.
- R7: Index n is paired with length register n. The modify register used is number 4*(n div 4) + `acc_mod`, so it always comes from the same half as the index.
- R8: `addr_pm_o` is high only when `acc_en` and `acc_pm` are both high and `acc_num` is in the upper half (4..7). In every other case it is low.
- R9: A register write to index n in the same cycle as an access on index n wins. The index takes the written value, and the address output in that cycle still shows the old index.
- R10: A pointer changes only through a write or through an access on that pointer. Idle cycles and accesses on other pointers leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind: 0 index, 1 modify, 2 length, 3 none |
| wr_num | input | 3 | Register number 0..7 |
| wr_data | input | 14 | Write data |
| rd_kind | input | 2 | Read kind, same encoding as `wr_kind` |
| rd_num | input | 3 | Read register number |
| rd_data | output | 14 | Combinational read data |
| acc_en | input | 1 | Access strobe |
| acc_num | input | 3 | Index register used by the access |
| acc_mod | input | 2 | Modify register within the index's half |
| acc_pm | input | 1 | Request program-memory space (upper half only) |
| addr_o | output | 14 | Generated address |
| addr_vld_o | output | 1 | Address valid |
| addr_pm_o | output | 1 | Address targets program memory |

## Verification
A wrong wrap or base computation leaves a bad pointer after the access edge. It shows up at the very next access of that pointer as a wrong `addr_o`, or at once on the read port. A mis-paired modify or length register only shows when the registers involved hold different values, so the stimulus loads distinct values across both halves. A broken write priority or a stray update shows as a read-back mismatch in the cycle right after the offending edge.

// File: rtl/circ_agu_pkg.sv
package circ_agu_pkg;
  typedef enum logic [1:0] {
    KIND_IDX  = 2'd0,
    KIND_MOD  = 2'd1,
    KIND_LEN  = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;

  localparam int NUM_HALVES = 2;
endpackage

// File: rtl/agu_wrap.sv
module agu_wrap #(
  parameter int AW = 14
) (
  input  logic [AW-1:0] idx_i,
  input  logic [AW-1:0] mod_i,
  input  logic [AW-1:0] len_i,
  output logic [AW-1:0] nxt_o
);
  localparam int SW = AW + 2;

  // fill every bit below the highest set bit
  function automatic logic [AW-1:0] smear(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    r = v;
    for (int k = 1; k < AW; k = k * 2) r = r | (r >> k);
    return r;
  endfunction

  logic [AW-1:0]        span_mask;
  logic [AW-1:0]        base;
  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] lim;
  logic signed [SW-1:0] len_s;
  logic signed [SW-1:0] res;

  always_comb begin
    span_mask = smear(len_i - AW'(1));
    base      = idx_i & ~span_mask;
    len_s     = $signed({2'b00, len_i});
    sum       = $signed({2'b00, idx_i}) + $signed({{2{mod_i[AW-1]}}, mod_i});
    lim       = $signed({2'b00, base}) + len_s;
    res       = sum;
    if (len_i != '0) begin
      if (!mod_i[AW-1] && (sum >= lim))                      res = sum - len_s;
      else if (mod_i[AW-1] && (sum < $signed({2'b00, base}))) res = sum + len_s;
    end
    nxt_o = res[AW-1:0];
  end
endmodule

// File: rtl/agu_half.sv
module agu_half
  import circ_agu_pkg::*;
#(
  parameter int AW   = 14,
  parameter int NPER = 4,
  localparam int HW  = (NPER > 1) ? $clog2(NPER) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_kind,
  input  logic [HW-1:0] wr_slot,
  input  logic [AW-1:0] wr_data,
  input  logic [1:0]    rd_kind,
  input  logic [HW-1:0] rd_slot,
  output logic [AW-1:0] rd_data,
  input  logic          acc_en,
  input  logic [HW-1:0] acc_slot,
  input  logic [HW-1:0] acc_mod,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] idx_q [NPER];
  logic [AW-1:0] mod_q [NPER];
  logic [AW-1:0] len_q [NPER];
  logic [AW-1:0] nxt;

  assign addr = idx_q[acc_slot];

  agu_wrap #(.AW(AW)) u_wrap (
    .idx_i (idx_q[acc_slot]),
    .mod_i (mod_q[acc_mod]),
    .len_i (len_q[acc_slot]),
    .nxt_o (nxt)
  );

  for (genvar k = 0; k < NPER; k++) begin : g_slot
    logic wr_hit;
    assign wr_hit = wr_en && (wr_slot == HW'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx_q[k] <= '0;
        mod_q[k] <= '0;
        len_q[k] <= '0;
      end else begin
        if (wr_hit && wr_kind == KIND_IDX)      idx_q[k] <= wr_data;
        else if (acc_en && acc_slot == HW'(k))  idx_q[k] <= nxt;
        if (wr_hit && wr_kind == KIND_MOD)      mod_q[k] <= wr_data;
        if (wr_hit && wr_kind == KIND_LEN)      len_q[k] <= wr_data;
      end
    end
  end

  always_comb begin
    unique case (rd_kind)
      KIND_IDX: rd_data = idx_q[rd_slot];
      KIND_MOD: rd_data = mod_q[rd_slot];
      KIND_LEN: rd_data = len_q[rd_slot];
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/circ_agu.sv
module circ_agu
  import circ_agu_pkg::*;
#(
  parameter int AW   = 14,
  parameter int NREG = 8,
  localparam int IW   = $clog2(NREG),
  localparam int NPER = NREG / NUM_HALVES,
  localparam int HW   = (NPER > 1) ? $clog2(NPER) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_kind,
  input  logic [IW-1:0] wr_num,
  input  logic [AW-1:0] wr_data,
  input  logic [1:0]    rd_kind,
  input  logic [IW-1:0] rd_num,
  output logic [AW-1:0] rd_data,
  input  logic          acc_en,
  input  logic [IW-1:0] acc_num,
  input  logic [HW-1:0] acc_mod,
  input  logic          acc_pm,
  output logic [AW-1:0] addr_o,
  output logic          addr_vld_o,
  output logic          addr_pm_o
);
  logic [AW-1:0] half_rd   [NUM_HALVES];
  logic [AW-1:0] half_addr [NUM_HALVES];

  logic acc_hi;
  assign acc_hi = acc_num[IW-1];

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    agu_half #(.AW(AW), .NPER(NPER)) u_half (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en && (wr_num[IW-1] == 1'(h))),
      .wr_kind  (wr_kind),
      .wr_slot  (wr_num[HW-1:0]),
      .wr_data  (wr_data),
      .rd_kind  (rd_kind),
      .rd_slot  (rd_num[HW-1:0]),
      .rd_data  (half_rd[h]),
      .acc_en   (acc_en && (acc_hi == 1'(h))),
      .acc_slot (acc_num[HW-1:0]),
      .acc_mod  (acc_mod),
      .addr     (half_addr[h])
    );
  end

  assign rd_data    = half_rd[rd_num[IW-1]];
  assign addr_o     = acc_en ? half_addr[acc_hi] : '0;
  assign addr_vld_o = acc_en;
  // only the upper generator may steer to program memory
  assign addr_pm_o  = acc_en && acc_pm && acc_hi;
endmodule

// File: rtl/circ_agu_chk.sv
module circ_agu_chk #(
  parameter int AW   = 14,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG),
  localparam int HW  = ((NREG / 2) > 1) ? $clog2(NREG / 2) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_kind,
  input logic [IW-1:0] wr_num,
  input logic [AW-1:0] wr_data,
  input logic [1:0]    rd_kind,
  input logic [IW-1:0] rd_num,
  input logic [AW-1:0] rd_data,
  input logic          acc_en,
  input logic [IW-1:0] acc_num,
  input logic [HW-1:0] acc_mod,
  input logic          acc_pm,
  input logic [AW-1:0] addr_o,
  input logic          addr_vld_o,
  input logic          addr_pm_o
);
  // R8: lower half never targets program memory
  a_r8_lower_dm: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_num[IW-1]) |-> !addr_pm_o);

  // R3, R8: outputs quiet without an access
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (!addr_pm_o && !addr_vld_o && addr_o == '0));

  // R3: the address matches the index seen through the read port
  a_r3_addr_matches_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && rd_kind == 2'd0 && rd_num == acc_num) |-> addr_o == rd_data);

  // R2: a written register reads back its data on the next cycle
  a_r2_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_kind != 2'd3) |=>
      (!(rd_kind == $past(wr_kind) && rd_num == $past(wr_num)) || rd_data == $past(wr_data)));

  // R10: with no write and no access, a steady read selection stays steady
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !wr_en) |=> (!$stable(rd_kind) || !$stable(rd_num) || $stable(rd_data)));
endmodule

bind circ_agu circ_agu_chk #(.AW(AW), .NREG(NREG)) u_chk (.*);

// File: tb/sim_circ_agu.sv
module sim_circ_agu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_kind = '0;
  logic [2:0]  wr_num = '0;
  logic [13:0] wr_data = '0;
  logic [1:0]  rd_kind = '0;
  logic [2:0]  rd_num = '0;
  logic [13:0] rd_data;
  logic        acc_en = 1'b0;
  logic [2:0]  acc_num = '0;
  logic [1:0]  acc_mod = '0;
  logic        acc_pm = 1'b0;
  logic [13:0] addr_o;
  logic        addr_vld_o;
  logic        addr_pm_o;

  int checks = 0;
  int errors = 0;
  int mI[8];
  int mM[8];
  int mL[8];

  always #5 clk = ~clk;

  circ_agu u0 (.*);

  function automatic int sx(int v);
    v = v & 16383;
    return (v >= 8192) ? v - 16384 : v;
  endfunction

  function automatic int nxt_idx(int i, int m, int l);
    int p, base, s;
    if (l == 0) return (i + m) & 16383;
    p = 1;
    while (p < l) p = p * 2;
    base = i & ~(p - 1);
    s = i + m;
    if (m >= 0 && s >= base + l) s = s - l;
    else if (m < 0 && s < base) s = s + l;
    return s & 16383;
  endfunction

  function automatic int model_get(int kind, int num);
    case (kind)
      0: return mI[num];
      1: return mM[num] & 16383;
      2: return mL[num];
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_wr(int kind, int num, int data);
    case (kind)
      0: mI[num] = data & 16383;
      1: mM[num] = sx(data);
      2: mL[num] = data & 16383;
      default: ;
    endcase
  endtask

  task automatic do_wr(int kind, int num, int data);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'(kind); wr_num = 3'(num); wr_data = 14'(data);
    @(posedge clk);
    model_wr(kind, num, data);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, int kind, int num);
    @(negedge clk);
    rd_kind = 2'(kind); rd_num = 3'(num);
    #1 chk(req, int'(rd_data), model_get(kind, num));
  endtask

  task automatic do_acc(string req, int num, int mi, int pm, int also_wr = 0, int wdata = 0);
    int mnum;
    mnum = (num / 4) * 4 + mi;
    @(negedge clk);
    acc_en = 1'b1; acc_num = 3'(num); acc_mod = 2'(mi); acc_pm = 1'(pm);
    if (also_wr != 0) begin
      wr_en = 1'b1; wr_kind = 2'd0; wr_num = 3'(num); wr_data = 14'(wdata);
    end
    #1;
    chk({req, " addr"}, int'(addr_o), mI[num]);
    chk("R3 vld", int'(addr_vld_o), 1);
    chk("R8 pm", int'(addr_pm_o), (pm != 0 && num >= 4) ? 1 : 0);
    @(posedge clk);
    if (also_wr != 0) mI[num] = wdata & 16383;
    else mI[num] = nxt_idx(mI[num], mM[mnum], mL[num]);
    #1 acc_en = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 8; k++) begin mI[k] = 0; mM[k] = 0; mL[k] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    for (int k = 0; k < 8; k++)
      for (int t = 0; t < 3; t++) rd_chk("R1 reset", t, k);
    @(negedge clk);
    chk("R3 idle vld", int'(addr_vld_o), 0);
    chk("R3 idle addr", int'(addr_o), 0);

    // R2: write/readback, kind 3 ignored
    do_wr(0, 3, 1234); rd_chk("R2 idx", 0, 3);
    do_wr(1, 6, 16000); rd_chk("R2 mod", 1, 6);
    do_wr(2, 7, 99); rd_chk("R2 len", 2, 7);
    do_wr(3, 3, 777); rd_chk("R2 kind3 ignored", 0, 3);
    rd_chk("R2 kind3 read", 3, 3);

    // R4: linear with wrap at 2^14
    do_wr(0, 0, 16380); do_wr(1, 0, 5);
    do_acc("R4 linear", 0, 0, 0);
    rd_chk("R4 wrap up", 0, 0);
    chk("R4 value", mI[0], 1);
    do_wr(1, 1, 14'(-3));
    do_acc("R4 neg", 0, 1, 0);
    chk("R4 wrap down", mI[0], 16382);
    rd_chk("R4 readback", 0, 0);

    // R5: positive wrap, buffer 8..12
    do_wr(0, 1, 10); do_wr(2, 1, 5); do_wr(1, 2, 3);
    do_acc("R5 pos", 1, 2, 0);
    chk("R5 wrap", mI[1], 8);
    do_acc("R5 pos2", 1, 2, 0);
    do_acc("R5 pos3", 1, 2, 0);
    chk("R5 wrap2", mI[1], 9);
    rd_chk("R5 readback", 0, 1);

    // R6: negative wrap
    do_wr(1, 3, 14'(-3));
    do_acc("R6 neg", 1, 3, 0);
    chk("R6 wrap", mI[1], 11);
    rd_chk("R6 readback", 0, 1);
    // length 1 pins the pointer
    do_wr(0, 2, 7); do_wr(2, 2, 1); do_wr(1, 0, 1);
    do_acc("R5 len1", 2, 0, 0);
    chk("R5 len1 stays", mI[2], 7);

    // R7: upper half uses its own modify registers
    do_wr(1, 5, 7); do_wr(1, 1, 100); do_wr(0, 5, 0);
    do_acc("R7 upper", 5, 1, 0);
    chk("R7 modify pairing", mI[5], 7);
    rd_chk("R7 readback", 0, 5);
    rd_chk("R10 other idx untouched", 0, 1);

    // R8: program-memory select
    do_acc("R8 lower pm", 2, 0, 1);
    do_acc("R8 upper pm", 6, 0, 1);
    do_acc("R8 upper dm", 6, 0, 0);

    // R9: write wins over access
    do_acc("R9 collide", 1, 2, 0, 1, 50);
    rd_chk("R9 write wins", 0, 1);
    chk("R9 value", mI[1], 50);

    // R10: idle cycles
    repeat (4) @(posedge clk);
    for (int k = 0; k < 8; k++) rd_chk("R10 idle", 0, k);

    // random mix
    for (int it = 0; it < 400; it++) begin
      int r, kind, num, data;
      r = $urandom % 4;
      num = $urandom % 8;
      if (r == 0) begin
        kind = $urandom % 4;
        case ($urandom % 3)
          0: data = 0;
          1: data = 1 + $urandom % 40;
          default: data = $urandom % 16384;
        endcase
        if (kind == 1 && ($urandom % 2) == 0) data = (($urandom % 41) - 20) & 16383;
        do_wr(kind, num, data);
      end else begin
        do_acc("R5 R6 random", num, $urandom % 4, $urandom % 2);
      end
      if (it % 50 == 49)
        for (int k = 0; k < 8; k++) rd_chk("R10 random readback", 0, k);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule